// File: doc/BRIEF.md
# Serial interrupt peripheral encoder

This block is the peripheral side of a single-wire serial interrupt bus. The wire is shared and open-drain: every agent either pulls it low, drives it high, or leaves it alone, and a pull-up holds it high when nobody drives. The block watches the resolved wire and recognises a start frame as a low pulse. From the rising edge that ends the start frame it counts fixed-length data frames. In the one frame whose index matches its configured slot, it reports the level of a local interrupt signal.

Each data frame lasts three clocks: sample, recovery and turn-around. In its own sample clock the block pulls the wire low when the interrupt input is low. In the recovery clock that follows, and only then, it drives the wire high to restore it quickly. It releases the wire in the turn-around clock. After the last data frame the host sends a stop pulse, and its length selects the next mode. In continuous mode the host starts every cycle. In quiet mode the wire idles high, and the peripheral may pull it low for a single clock when its interrupt level has changed since it was last reported. The host then completes the start frame.

The wire is driven only through an output enable paired with a drive value. The integrating logic builds the pad from them.

Top module: `sline_irq_encoder`

## Requirements
- R1: While reset is asserted, and directly after it, the output enable is 0 and the block is in continuous mode (`quiet_active` = 0).
- R2: After one or more clocks with the wire sampled low, the first clock edge that samples it high ends the start frame. The sample clock of frame 0 is the clock cycle right after that edge. Frame i then occupies clocks 3i, 3i+1 and 3i+2 from that point, in the order sample, recovery, turn-around, for NUM_FRAMES frames (default 21).
- R3: In the sample clock of frame `slot_idx`, the block drives the wire low (`bus_oe`=1, `bus_drive_val`=0) when `irq_level` is 0 and leaves it released (`bus_oe`=0) when `irq_level` is 1.
- R4: In the recovery clock of its own frame, the block drives the wire high (`bus_oe`=1, `bus_drive_val`=1) only if it drove low in the sample clock just before. Otherwise it releases the wire.
- R5: The wire is released in every turn-around clock, during start and stop frames, and in every data frame other than its own. The only exceptions are R3, R4 and the single wakeup clock of R8.
- R6: A `slot_idx` of NUM_FRAMES or more never causes a drive in any data frame.
- R7: The stop pulse is the run of low clocks that begins right after the last turn-around. A 2-clock run selects quiet mode and a 3-clock run selects continuous mode. Any other length leaves the mode unchanged. The new mode shows on `quiet_active` from the second clock after the wire returns high.
- R8: In quiet mode, while idle with the wire high, a difference between `irq_level` and the level last reported in its own sample clock makes the block drive the wire low for exactly one clock and then release it. The last reported level is 0 after reset. After the wakeup clock the block treats the cycle as a start frame.
- R9: No wakeup drive occurs in continuous mode, or in quiet mode when `irq_level` equals the last reported level.
- R10: If the wire is sampled low in a recovery or turn-around clock, the block abandons the frame count. It then drives nothing until a new start frame has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Resolved level of the shared wire |
| irq_level | input | 1 | Local interrupt level to report |
| slot_idx | input | SLOT_W | Index of the data frame this peripheral owns |
| bus_oe | output | 1 | Drive enable for the shared wire |
| bus_drive_val | output | 1 | Level driven when `bus_oe` is 1 |
| quiet_active | output | 1 | 1 in quiet mode, 0 in continuous mode |

## Verification
The bench sweeps every slot index, including the invalid one, with both interrupt levels and with start pulses of 4, 6 and 8 clocks. It compares the drive in every data clock against values computed from the frame arithmetic. A frame counter that started one clock early or late would move the drive into a neighbouring frame. A missing recovery-high clock, or a recovery drive without a preceding low, would show up in the clock after the sample. Stop pulses of 1, 2, 3 and 4 clocks are sent to catch a decoder that takes any long pulse as a mode change. The wakeup tests check that exactly one low clock appears in quiet mode only when the level changed, and that none appears otherwise. A low injected into a recovery clock checks that a design which kept counting after the glitch would wrongly drive in a later slot.

// File: rtl/sline_irq_pkg.sv
package sline_irq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_START,
      ST_DATA,
      ST_STOP
   } bus_state_t;

   typedef enum logic [1:0] {
      PH_SAMPLE,
      PH_RECOVER,
      PH_TURN
   } phase_t;

endpackage

// File: rtl/sline_frame_tracker.sv
module sline_frame_tracker
   import sline_irq_pkg::*;
#(
   parameter int NUM_FRAMES     = 21,
   parameter int SLOT_W         = 5,
   parameter int QUIET_STOP_LEN = 2,
   parameter int CONT_STOP_LEN  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_in,
   input  logic              wake_req,
   output bus_state_t        state,
   output phase_t            phase,
   output logic [SLOT_W-1:0] frame_idx,
   output logic              quiet_mode
);

   localparam int STOP_SAT = ((QUIET_STOP_LEN > CONT_STOP_LEN) ? QUIET_STOP_LEN : CONT_STOP_LEN) + 1;
   localparam int CNT_W    = $clog2(STOP_SAT + 1);
   localparam logic [SLOT_W-1:0] LAST_FRAME = SLOT_W'(NUM_FRAMES - 1);
   localparam logic [CNT_W-1:0]  QLEN       = CNT_W'(QUIET_STOP_LEN);
   localparam logic [CNT_W-1:0]  CLEN       = CNT_W'(CONT_STOP_LEN);
   localparam logic [CNT_W-1:0]  SAT        = CNT_W'(STOP_SAT);

   initial begin
      assert (QUIET_STOP_LEN >= 1 && CONT_STOP_LEN >= 1)
         else $fatal(1, "stop lengths must be at least one clock");
      assert (QUIET_STOP_LEN != CONT_STOP_LEN)
         else $fatal(1, "stop lengths must differ");
   end

   logic [CNT_W-1:0] stop_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         phase      <= PH_SAMPLE;
         frame_idx  <= '0;
         stop_cnt   <= '0;
         quiet_mode <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (!bus_in)       state <= ST_START;
               else if (wake_req) state <= ST_WAKE;
            end
            ST_WAKE: state <= ST_START;
            ST_START: begin
               if (bus_in) begin
                  state     <= ST_DATA;
                  phase     <= PH_SAMPLE;
                  frame_idx <= '0;
               end
            end
            ST_DATA: begin
               if (phase != PH_SAMPLE && !bus_in) begin
                  state <= ST_IDLE;
                  phase <= PH_SAMPLE;
               end else begin
                  case (phase)
                     PH_SAMPLE:  phase <= PH_RECOVER;
                     PH_RECOVER: phase <= PH_TURN;
                     default: begin
                        phase <= PH_SAMPLE;
                        if (frame_idx == LAST_FRAME) begin
                           state    <= ST_STOP;
                           stop_cnt <= '0;
                        end else begin
                           frame_idx <= frame_idx + 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_STOP: begin
               if (!bus_in) begin
                  if (stop_cnt != SAT) stop_cnt <= stop_cnt + 1'b1;
               end else begin
                  if (stop_cnt == QLEN)      quiet_mode <= 1'b1;
                  else if (stop_cnt == CLEN) quiet_mode <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: a low in recovery or turn-around abandons the count
   a_r10_abort_on_glitch: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && phase != PH_SAMPLE && !bus_in) |=> (state == ST_IDLE));

   // R7: the mode moves only out of a stop frame
   a_r7_mode_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quiet_mode) |-> $past(state == ST_STOP));

   // R2: the frame index stays inside the data window
   a_r2_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> (frame_idx <= LAST_FRAME));

endmodule

// File: rtl/sline_line_driver.sv
module sline_line_driver
   import sline_irq_pkg::*;
#(
   parameter int NUM_FRAMES = 21,
   parameter int SLOT_W     = 5,
   parameter bit WAKE_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_state_t        state,
   input  phase_t            phase,
   input  logic [SLOT_W-1:0] frame_idx,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic              irq_level,
   input  logic              quiet_mode,
   output logic              bus_oe,
   output logic              bus_drive_val,
   output logic              wake_req
);

   localparam logic [SLOT_W-1:0] FRAME_LIMIT = SLOT_W'(NUM_FRAMES);

   logic slot_valid;
   logic own_frame;
   logic own_sample;
   logic sample_drv;
   logic recov_drv;
   logic wake_drv;
   logic drove_low;

   assign slot_valid = (slot_idx < FRAME_LIMIT);
   assign own_frame  = (state == ST_DATA) && slot_valid && (frame_idx == slot_idx);
   assign own_sample = own_frame && (phase == PH_SAMPLE);
   assign sample_drv = own_sample && !irq_level;
   assign recov_drv  = drove_low && (state == ST_DATA) && (phase == PH_RECOVER);
   assign wake_drv   = (state == ST_WAKE);

   assign bus_oe        = sample_drv | recov_drv | wake_drv;
   assign bus_drive_val = recov_drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drove_low <= 1'b0;
      else        drove_low <= sample_drv;
   end

   generate
      if (WAKE_EN) begin : g_wake
         logic last_rep;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          last_rep <= 1'b0;
            else if (own_sample) last_rep <= irq_level;
         end
         assign wake_req = quiet_mode && (irq_level != last_rep);
      end else begin : g_no_wake
         assign wake_req = 1'b0;
      end
   endgenerate

   // R4: a high drive only ever follows a low drive
   a_r4_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && bus_drive_val) |-> $past(bus_oe && !bus_drive_val));

   // R8: the wakeup drive lasts a single clock
   a_r8_wake_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |=> !bus_oe);

   // R9: wakeup only from quiet mode
   a_r9_wake_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE) |-> quiet_mode);

   // R6: an out-of-range slot never drives a data frame
   a_r6_bad_slot_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_valid && state == ST_DATA) |-> !bus_oe);

endmodule

// File: rtl/sline_irq_encoder.sv
module sline_irq_encoder
   import sline_irq_pkg::*;
#(
   parameter int NUM_FRAMES     = 21,
   parameter int SLOT_W         = $clog2(NUM_FRAMES + 1),
   parameter int QUIET_STOP_LEN = 2,
   parameter int CONT_STOP_LEN  = 3,
   parameter bit WAKE_EN        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_in,
   input  logic              irq_level,
   input  logic [SLOT_W-1:0] slot_idx,
   output logic              bus_oe,
   output logic              bus_drive_val,
   output logic              quiet_active
);

   initial begin
      assert (NUM_FRAMES >= 1)
         else $fatal(1, "at least one data frame is needed");
      assert ((1 << SLOT_W) > NUM_FRAMES)
         else $fatal(1, "slot width too narrow for the frame count");
   end

   bus_state_t        state;
   phase_t            phase;
   logic [SLOT_W-1:0] frame_idx;
   logic              wake_req;

   sline_frame_tracker #(
      .NUM_FRAMES     (NUM_FRAMES),
      .SLOT_W         (SLOT_W),
      .QUIET_STOP_LEN (QUIET_STOP_LEN),
      .CONT_STOP_LEN  (CONT_STOP_LEN)
   ) u_tracker (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_in     (bus_in),
      .wake_req   (wake_req),
      .state      (state),
      .phase      (phase),
      .frame_idx  (frame_idx),
      .quiet_mode (quiet_active)
   );

   sline_line_driver #(
      .NUM_FRAMES (NUM_FRAMES),
      .SLOT_W     (SLOT_W),
      .WAKE_EN    (WAKE_EN)
   ) u_driver (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (state),
      .phase         (phase),
      .frame_idx     (frame_idx),
      .slot_idx      (slot_idx),
      .irq_level     (irq_level),
      .quiet_mode    (quiet_active),
      .bus_oe        (bus_oe),
      .bus_drive_val (bus_drive_val),
      .wake_req      (wake_req)
   );

   // R5: nothing is driven in idle, start or stop frames
   a_r5_silent_outside_data: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_START || state == ST_STOP) |-> !bus_oe);

   // R1: the mode is continuous in the first cycle after reset
   a_r1_reset_continuous: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !quiet_active);

endmodule

// File: tb/sline_irq_encoder_bench.sv
module sline_irq_encoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NF         = 21;
   localparam int SLOT_W     = $clog2(NF + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic irq = 1'b0;
   logic [SLOT_W-1:0] slot = '0;
   logic dut_oe, dut_val, quiet;
   logic bus_line;

   int n_checks = 0;
   int n_fail   = 0;
   bit exp_quiet = 1'b0;
   bit exp_last  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // wired bus: host pull-down wins, else DUT drive, else pull-up
   assign bus_line = host_low ? 1'b0 : (dut_oe ? dut_val : 1'b1);

   sline_irq_encoder #(.NUM_FRAMES(NF)) u_sline_irq_encoder (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_in        (bus_line),
      .irq_level     (irq),
      .slot_idx      (slot),
      .bus_oe        (dut_oe),
      .bus_drive_val (dut_val),
      .quiet_active  (quiet)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_drive(input string req, input bit e_oe, input bit e_val);
      int act;
      int exp;
      act = {30'd0, dut_oe, dut_oe ? dut_val : 1'b0};
      exp = {30'd0, e_oe, e_oe ? e_val : 1'b0};
      chk(act == exp, req, act, exp);
   endtask

   task automatic cyc(input bit low);
      @(negedge clk);
      host_low = low;
      #1;
   endtask

   // One host cycle: start pulse, release clock, data frames, stop pulse
   task automatic run_cycle(input int s, input bit lvl, input int start_low, input int stop_len);
      slot = SLOT_W'(s);
      irq  = lvl;
      for (int i = 0; i < start_low; i++) begin
         cyc(1'b1);
         chk_drive("R5 start", 1'b0, 1'b0);
      end
      cyc(1'b0);
      chk_drive("R2 release", 1'b0, 1'b0);
      for (int f = 0; f < NF; f++) begin
         for (int p = 0; p < 3; p++) begin
            bit mine;
            bit e_oe;
            cyc(1'b0);
            mine = (f == s) && (s < NF);
            e_oe = mine && !lvl && (p < 2);
            if (s >= NF)     chk_drive("R6", 1'b0, 1'b0);
            else if (p == 0) chk_drive("R3", e_oe, 1'b0);
            else if (p == 1) chk_drive("R4", e_oe, 1'b1);
            else             chk_drive("R5 turn", 1'b0, 1'b0);
         end
      end
      if (s < NF) exp_last = lvl;
      for (int i = 0; i < stop_len; i++) begin
         cyc(1'b1);
         chk_drive("R5 stop", 1'b0, 1'b0);
      end
      cyc(1'b0);
      chk_drive("R5 stop end", 1'b0, 1'b0);
      if (stop_len == 2)      exp_quiet = 1'b1;
      else if (stop_len == 3) exp_quiet = 1'b0;
      cyc(1'b0);
      chk(quiet == exp_quiet, "R7 mode", int'(quiet), int'(exp_quiet));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk_drive("R1", 1'b0, 1'b0);
      chk(quiet == 1'b0, "R1 mode", int'(quiet), 0);
      rst_n = 1'b1;
      cyc(1'b0);
      chk_drive("R1", 1'b0, 1'b0);
      chk(quiet == 1'b0, "R1 mode", int'(quiet), 0);

      // R2 R3 R4 R6: sweep every slot (plus one invalid) and both levels
      for (int s = 0; s <= NF; s++) begin
         for (int l = 0; l < 2; l++) begin
            run_cycle(s, l[0], 4 + 2 * (s % 3), 3);
         end
      end

      // R7: enter quiet mode with a 2-clock stop
      run_cycle(5, exp_last, 4, 2);

      // R9: quiet, level unchanged, no wakeup
      for (int i = 0; i < 5; i++) begin
         cyc(1'b0);
         chk_drive("R9 unchanged", 1'b0, 1'b0);
      end

      // R8: level change in quiet mode gives exactly one low clock
      @(negedge clk);
      irq = ~exp_last;
      host_low = 1'b0;
      #1;
      chk_drive("R8 before", 1'b0, 1'b0);
      cyc(1'b0);
      chk_drive("R8 wake", 1'b1, 1'b0);
      run_cycle(5, irq, 3, 2);

      // R7: invalid stop lengths keep quiet mode
      run_cycle(7, exp_last, 4, 1);
      run_cycle(7, exp_last, 4, 4);
      // R7: back to continuous
      run_cycle(7, exp_last, 6, 3);

      // R9: level change in continuous mode gives no wakeup
      @(negedge clk);
      irq = ~exp_last;
      host_low = 1'b0;
      #1;
      for (int i = 0; i < 6; i++) begin
         cyc(1'b0);
         chk_drive("R9 continuous", 1'b0, 1'b0);
      end

      // R10: glitch low in a recovery clock abandons the count
      slot = SLOT_W'(10);
      irq  = 1'b0;
      for (int i = 0; i < 4; i++) cyc(1'b1);
      cyc(1'b0);
      for (int i = 0; i < 3 * 3; i++) cyc(1'b0);
      cyc(1'b0);          // frame 3 sample
      cyc(1'b1);          // frame 3 recovery, host glitch
      for (int i = 0; i < 3 * NF; i++) begin
         cyc(1'b0);
         chk_drive("R10 silent", 1'b0, 1'b0);
      end
      run_cycle(10, 1'b0, 4, 3);

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule